// File: doc/BRIEF.md
# Conditional Call/Return Control Unit

This block sequences a program held in a ring of 64-bit instruction words. It owns the program counter, an instruction countdown and an on-chip return stack. Each accepted step presents the class of the instruction being executed, its two operand values, an 8-bit jump immediate and a 32-bit compare immediate. The block answers with the address of the next instruction, an optional destination write value, and a flag that rises once the instruction budget is used up.

Three control-flow classes are handled. A forward call with a static offset and a forward call with a data-dependent offset both save a value and a return address on the stack. A return restores both. Each of them acts only when the B operand does not exceed the compare immediate. Otherwise it degrades into a plain copy of A to the destination. Every other class just advances the program counter and spends one unit of the budget. Fetch, operand decode and arithmetic belong to neighbouring blocks.

Top module: `cflow_unit`

## Requirements
- R1: After reset, next_pc is 0, stack_ptr is 0, done and overflow are 0, and result_wr is 0.
- R2: The class encoding is 2'b00 plain, 2'b01 static call, 2'b10 dynamic call and 2'b11 return. A plain step sets next_pc to next_pc+8, taken modulo the ring size of PROG_WORDS*8 bytes, so the program wraps to address 0. The address always stays 8-byte aligned.
- R3: The countdown starts at INSTR_COUNT (default 65536) and drops by one for every accepted step. done is 1 while it is zero. Steps presented while done is 1 change no output.
- R4: A call or return condition holds when opnd_b <= imm1, with both treated as unsigned 64-bit values and imm1 zero-extended. The equal case counts as taken.
- R5: A call or return whose condition fails writes result = opnd_a with result_wr = 1. It advances next_pc by 8 and leaves stack_ptr unchanged.
- R6: A taken static call places opnd_a on the stack, then the address of the following instruction. It raises stack_ptr by 16 and sets next_pc = next_pc + 8*(imm0+1), modulo the ring size. It makes no destination write.
- R7: A taken dynamic call pushes in the same way as a static call. Its jump offset is 8*((imm0 XOR opnd_a[63:56])+1).
- R8: A taken return first removes the top entry and uses it as the new next_pc. It then removes the entry below, which becomes result with result_wr = 1. stack_ptr falls by 16.
- R9: A return is treated as not taken when fewer than two entries are on the stack, and then behaves as in R5.
- R10: A taken call with fewer than two free entries still jumps but pushes nothing and leaves stack_ptr unchanged. It sets overflow, and overflow stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_valid | input | 1 | One instruction is executed this cycle |
| instr_class | input | 2 | Instruction class (encoding in R2) |
| opnd_a | input | 64 | Operand A value |
| opnd_b | input | 64 | Operand B value |
| imm0 | input | 8 | Jump offset immediate |
| imm1 | input | 32 | Compare immediate |
| next_pc | output | 64 | Byte address of the next instruction |
| result | output | 64 | Destination value |
| result_wr | output | 1 | result is to be written (one cycle per step) |
| stack_ptr | output | 64 | Stack pointer in bytes, 8 per entry |
| done | output | 1 | Instruction budget exhausted |
| overflow | output | 1 | Sticky: a call found the stack full |

## Verification
All results are registered, so each output reflects a step at the first rising edge after that step is presented. The bench drives a step on a falling edge. It then waits for the next rising edge and compares every output with its behavioural model at the falling edge that follows, before driving the next step. result_wr is a one-cycle pulse tied to that same edge, so each step is judged against its own expected write. The done flag and the ignored steps after it are checked in the same way.

// File: rtl/cflow_pkg.sv
package cflow_pkg;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'b00,
        CLS_SCALL = 2'b01,
        CLS_DCALL = 2'b10,
        CLS_RET   = 2'b11
    } instr_class_e;

endpackage

// File: rtl/cflow_branch_eval.sv
module cflow_branch_eval
    import cflow_pkg::*;
#(
    parameter int PC_W = 13
) (
    input  logic [1:0]      cls,
    input  logic [7:0]      a_top,
    input  logic [63:0]     b_val,
    input  logic [7:0]      imm0,
    input  logic [31:0]     imm1,
    input  logic [PC_W-1:0] pc,
    output logic            cond,
    output logic [PC_W-1:0] seq_pc,
    output logic [PC_W-1:0] jump_pc
);
    logic [7:0]      off_sel;
    logic [PC_W-1:0] offset;

    always_comb begin
        cond    = (b_val <= {32'b0, imm1});
        off_sel = (instr_class_e'(cls) == CLS_DCALL) ? (imm0 ^ a_top) : imm0;
        offset  = PC_W'({off_sel, 3'b000}) + PC_W'(8);
        seq_pc  = pc + PC_W'(8);
        jump_pc = pc + offset;
    end

endmodule

// File: rtl/cflow_stack.sv
module cflow_stack #(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           push,
    input  logic [IDX_W:0] level,
    input  logic [63:0]    val_lo,
    input  logic [63:0]    val_hi,
    output logic [63:0]    top_entry,
    output logic [63:0]    below_entry
);
    logic [63:0]      mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] below_idx;

    always_comb begin
        wr_idx    = IDX_W'(level);
        top_idx   = IDX_W'(level - 1'b1);
        below_idx = IDX_W'(level - 2'd2);
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx]        <= val_lo;
            mem[wr_idx + 1'b1] <= val_hi;
        end
    end

    assign top_entry   = mem[top_idx];
    assign below_entry = mem[below_idx];

endmodule

// File: rtl/cflow_unit.sv
module cflow_unit
    import cflow_pkg::*;
#(
    parameter int PROG_WORDS  = 1024,
    parameter int STACK_DEPTH = 256,
    parameter int INSTR_COUNT = 65536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_valid,
    input  logic [1:0]  instr_class,
    input  logic [63:0] opnd_a,
    input  logic [63:0] opnd_b,
    input  logic [7:0]  imm0,
    input  logic [31:0] imm1,
    output logic [63:0] next_pc,
    output logic [63:0] result,
    output logic        result_wr,
    output logic [63:0] stack_ptr,
    output logic        done,
    output logic        overflow
);
    localparam int PC_W  = $clog2(PROG_WORDS * 8);
    localparam int IDX_W = $clog2(STACK_DEPTH);
    localparam int LVL_W = IDX_W + 1;
    localparam int IC_W  = $clog2(INSTR_COUNT + 1);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [LVL_W-1:0] lvl;
        logic [IC_W-1:0]  ic;
        logic             ovf;
        logic [63:0]      res;
        logic             res_wr;
    } state_t;

    state_t st_d, st_q;

    logic            cond;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] jump_pc;
    logic            push_en;
    logic            accept;
    logic [63:0]     top_entry;
    logic [63:0]     below_entry;
    logic            unused_bits;

    cflow_branch_eval #(.PC_W(PC_W)) u_eval (
        .cls     (instr_class),
        .a_top   (opnd_a[63:56]),
        .b_val   (opnd_b),
        .imm0    (imm0),
        .imm1    (imm1),
        .pc      (st_q.pc),
        .cond    (cond),
        .seq_pc  (seq_pc),
        .jump_pc (jump_pc)
    );

    cflow_stack #(.DEPTH(STACK_DEPTH), .IDX_W(IDX_W)) u_stack (
        .clk         (clk),
        .push        (push_en),
        .level       (st_q.lvl),
        .val_lo      (opnd_a),
        .val_hi      ({{(64-PC_W){1'b0}}, seq_pc}),
        .top_entry   (top_entry),
        .below_entry (below_entry)
    );

    assign unused_bits = ^{top_entry[63:PC_W], top_entry[2:0]};

    always_comb begin
        st_d        = st_q;
        st_d.res_wr = 1'b0;
        push_en     = 1'b0;
        accept      = step_valid && (st_q.ic != '0);
        if (accept) begin
            st_d.ic = st_q.ic - 1'b1;
            st_d.pc = seq_pc;
            unique case (instr_class_e'(instr_class))
                CLS_SCALL, CLS_DCALL: begin
                    if (cond) begin
                        st_d.pc = jump_pc;
                        if (st_q.lvl <= LVL_W'(STACK_DEPTH - 2)) begin
                            push_en  = 1'b1;
                            st_d.lvl = st_q.lvl + LVL_W'(2);
                        end else begin
                            st_d.ovf = 1'b1;
                        end
                    end else begin
                        st_d.res    = opnd_a;
                        st_d.res_wr = 1'b1;
                    end
                end
                CLS_RET: begin
                    if (cond && (st_q.lvl >= LVL_W'(2))) begin
                        st_d.pc     = {top_entry[PC_W-1:3], 3'b000};
                        st_d.res    = below_entry;
                        st_d.res_wr = 1'b1;
                        st_d.lvl    = st_q.lvl - LVL_W'(2);
                    end else begin
                        st_d.res    = opnd_a;
                        st_d.res_wr = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc     <= '0;
            st_q.lvl    <= '0;
            st_q.ic     <= IC_W'(INSTR_COUNT);
            st_q.ovf    <= 1'b0;
            st_q.res    <= '0;
            st_q.res_wr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc   = {{(64-PC_W){1'b0}}, st_q.pc};
    assign result    = st_q.res;
    assign result_wr = st_q.res_wr;
    assign stack_ptr = {{(61-LVL_W){1'b0}}, st_q.lvl, 3'b000};
    assign done      = (st_q.ic == '0);
    assign overflow  = st_q.ovf;

    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc[2:0] == 3'b000);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !done) |=> (st_q.ic == $past(st_q.ic) - 1'b1));

    assert_done_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(next_pc) && $stable(stack_ptr) && !result_wr));

    assert_sticky_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_stack_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LVL_W'(STACK_DEPTH));

    assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (st_q.lvl <= LVL_W'(STACK_DEPTH - 2)));

endmodule

// File: tb/cflow_unit_test.sv
`timescale 1ns/1ps
module cflow_unit_test;
    localparam int PW    = 1024;
    localparam int DEP   = 8;
    localparam int COUNT = 40;
    localparam longint unsigned RING = 64'(PW * 8);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0;
    logic [1:0]  instr_class = 2'b00;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [7:0]  imm0 = '0;
    logic [31:0] imm1 = '0;
    logic [63:0] next_pc, result, stack_ptr;
    logic        result_wr, done, overflow;

    int checks = 0;
    int fails  = 0;

    longint unsigned m_pc = 0;
    longint unsigned m_stk[$];
    int              m_ic = COUNT;
    bit              m_ovf = 0;
    bit              m_wr = 0;
    longint unsigned m_res = 0;

    always #2.5 clk = ~clk;

    cflow_unit #(.PROG_WORDS(PW), .STACK_DEPTH(DEP), .INSTR_COUNT(COUNT)) uut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .instr_class(instr_class),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm0(imm0), .imm1(imm1),
        .next_pc(next_pc), .result(result), .result_wr(result_wr),
        .stack_ptr(stack_ptr), .done(done), .overflow(overflow)
    );

    task automatic chk(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "next_pc", next_pc, m_pc);
        chk(tag, "stack_ptr", stack_ptr, 64'(m_stk.size() * 8));
        chk(tag, "done", 64'(done), 64'(m_ic == 0));
        chk(tag, "overflow", 64'(overflow), 64'(m_ovf));
        chk(tag, "result_wr", 64'(result_wr), 64'(m_wr));
        if (m_wr) chk(tag, "result", result, m_res);
    endtask

    // Behavioural reference of one step
    task automatic model(input logic [1:0] c, input longint unsigned a,
                         input longint unsigned b, input byte unsigned i0,
                         input int unsigned i1);
        longint unsigned seq, off, ra;
        bit take;
        m_wr = 0;
        if (m_ic == 0) return;
        m_ic--;
        seq  = (m_pc + 8) % RING;
        take = (b <= 64'(i1));
        if (c == 2'b01 || c == 2'b10) begin
            if (take) begin
                off = (c == 2'b10) ? 64'(i0 ^ byte'(a >> 56)) : 64'(i0);
                if (m_stk.size() + 2 <= DEP) begin
                    m_stk.push_back(a);
                    m_stk.push_back(seq);
                end else m_ovf = 1;
                m_pc = (m_pc + 8 * (off + 1)) % RING;
            end else begin
                m_wr = 1; m_res = a; m_pc = seq;
            end
        end else if (c == 2'b11) begin
            if (take && m_stk.size() >= 2) begin
                ra = m_stk.pop_back();
                m_res = m_stk.pop_back();
                m_wr = 1; m_pc = ra;
            end else begin
                m_wr = 1; m_res = a; m_pc = seq;
            end
        end else m_pc = seq;
    endtask

    task automatic step(input string tag, input logic [1:0] c, input longint unsigned a,
                        input longint unsigned b, input byte unsigned i0,
                        input int unsigned i1);
        model(c, a, b, i0, i1);
        instr_class = c; opnd_a = a; opnd_b = b; imm0 = i0; imm1 = i1;
        step_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step_valid = 1'b0;
        compare_all(tag);
    endtask

    initial begin
        #(5.0 * 20000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");
        // R2 plain steps
        step("R2", 2'b00, 64'h1, 64'h0, 8'h0, 32'h0);
        step("R2", 2'b00, 64'h2, 64'h0, 8'h0, 32'h0);
        // R9 return on empty stack behaves as copy
        step("R9", 2'b11, 64'hAAAA_0000_0000_5555, 64'h1, 8'h0, 32'h10);
        // R4/R5 B above imm1 only in upper bits: not taken
        step("R4", 2'b01, 64'h1234_5678_9ABC_DEF0, 64'h1_0000_0000, 8'h7, 32'hFFFF_FFFF);
        step("R5", 2'b10, 64'hCAFE, 64'h101, 8'h3, 32'h100);
        // R6 static call, B equal to imm1 (R4 boundary)
        step("R6", 2'b01, 64'hDEAD_BEEF_0000_0001, 64'h55, 8'h3, 32'h55);
        // R7 dynamic call with data offset
        step("R7", 2'b10, 64'h05FF_0000_0000_0042, 64'h0, 8'h02, 32'h0);
        // R8 two returns unwind
        step("R8", 2'b11, 64'h0, 64'h3, 8'h0, 32'h3);
        step("R8", 2'b11, 64'h0, 64'h0, 8'h0, 32'h9);
        // R2/R6 maximal jumps wrap the ring and fill the stack
        for (int k = 0; k < 4; k++)
            step("R6", 2'b01, 64'(k + 100), 64'h0, 8'hFF, 32'h0);
        // R10 call with full stack
        step("R10", 2'b01, 64'h77, 64'h0, 8'h10, 32'h0);
        step("R10", 2'b00, 64'h0, 64'h0, 8'h0, 32'h0);
        for (int k = 0; k < 4; k++)
            step("R8", 2'b11, 64'h0, 64'h0, 8'h0, 32'h0);
        // R9 again on emptied stack
        step("R9", 2'b11, 64'h99, 64'h0, 8'h0, 32'h0);
        // R3 run out the budget, then steps are ignored
        for (int k = 0; k < 30; k++)
            step("R3", (k % 3 == 0) ? 2'b01 : 2'b00, 64'(k), 64'h0, 8'(k), 32'h0);
        chk("R3", "done after budget", 64'(done), 64'h1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule